// File: doc/BRIEF.md
# Driver Fault Detection Latch

This block is the protection monitor of a two-phase unipolar stepper driver. It looks at the digital results of the analog sensing: one overcurrent comparator bit per phase, one bit per phase that says the sense voltage is above ground, and one overtemperature bit. It also receives two strobes per phase from the PWM generator. One is a single-cycle pulse at each PWM turn-off edge. The other is a level that is high while the PWM on-time lasts. From these inputs it detects a shorted coil, an open coil or an overheated die. It holds the result in a single fault latch, which turns off every phase output and raises an active-high fault flag.

A healthy coil pulls the sense node below ground while the PWM is off. A disconnected coil pushes it positive. Each phase therefore samples the polarity bit a fixed number of clock cycles after every turn-off edge, and counts positive samples in a row. The latch opens a phase fault only after three consecutive positive samples. Overcurrent and overtemperature cut the outputs in the same cycle and latch at the next clock edge. Only the deep-sleep input or the power-on reset clears the latch. While deep sleep is high the outputs are also held off.

Top module: `drv_fault_latch`

## Requirements
- R1: After power-on reset (rst_n low) fault_flag is 0 and every bit of drive_en is 1. Asserting rst_n low while a fault is latched clears the fault.
- R2: When any bit of oc_trip is 1, all drive_en bits are 0 in that same cycle. fault_flag is 1 from the next clock edge onward.
- R3: When hot_trip is 1, all drive_en bits are 0 in that same cycle. fault_flag is 1 from the next clock edge onward.
- R4: A one-cycle off_edge pulse on a phase, sampled at clock edge k, starts an off period. At edge k+SAMPLE_DLY (default 100 cycles, 2 us at 50 MHz), sense_pos of that phase is sampled, provided pwm_on stayed 0 until then. Three consecutive samples of 1 (OPEN_HITS) latch the fault.
- R5: A sample of 0 on a phase resets that phase's count of consecutive positive samples to zero.
- R6: An off period in which pwm_on returns to 1 before the sample point produces no sample. The count neither advances nor resets.
- R7: Each phase counts its own samples. Positive samples split across phases do not add up. A fault raised by either phase drives every drive_en bit to 0.
- R8: The value of sense_pos is ignored at every cycle except the sample point of an off period.
- R9: Once latched, the fault and fault_flag stay set after all fault inputs return to normal, until deep_sleep is 1 or rst_n is 0.
- R10: While deep_sleep is 1, every drive_en bit is 0. On the next edge fault_flag is 0 and both phase counters are cleared.
- R11: When no off_edge pulses arrive (pwm_on held at 1, constant drive), sense_pos at 1 never raises a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| deep_sleep | input | 1 | Deep-sleep request; clears the latch, holds outputs off |
| oc_trip | input | NPH | Per-phase overcurrent comparator result |
| hot_trip | input | 1 | Overtemperature comparator result |
| off_edge | input | NPH | Per-phase one-cycle pulse at PWM turn-off |
| pwm_on | input | NPH | Per-phase PWM on-time level |
| sense_pos | input | NPH | Per-phase sense voltage above ground |
| fault_flag | output | 1 | High while a fault is latched |
| drive_en | output | NPH | Per-phase output enable, low disables the phase |

## Verification
On every cycle the assertions check the following:
- A latched flag stays set until deep sleep.
- Overcurrent or overtemperature cuts every enable in its own cycle and sets the flag at the next edge.
- Deep sleep holds the enables low and leaves the flag clear.
- A set flag keeps both phases off.

Only the bench scenarios can show the open-coil behaviour, because it depends on history over hundreds of cycles:
- the sample point,
- the count of three in a row,
- the reset on a negative sample,
- short off periods that leave the count untouched,
- the separation of the two phases' counts,
- silence under constant drive.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;

    // Outcome of one open-coil polarity sample
    typedef enum logic [1:0] {
        SMP_NONE = 2'd0,
        SMP_NEG  = 2'd1,
        SMP_POS  = 2'd2
    } smp_e;

    // Reasons the latch may set, gathered each cycle
    typedef struct packed {
        logic shorted;
        logic hot;
        logic open;
    } cause_t;

endpackage

// File: rtl/drv_open_det.sv
module drv_open_det
    import drv_fault_pkg::*;
#(
    parameter int SAMPLE_DLY = 100,
    parameter int OPEN_HITS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic off_edge,
    input  logic pwm_on,
    input  logic sense_pos,
    output logic open_o
);

    localparam int TW = $clog2(SAMPLE_DLY + 1);
    localparam int CW = $clog2(OPEN_HITS + 1);
    localparam logic [TW-1:0] T_LAST = TW'(SAMPLE_DLY);
    localparam logic [CW-1:0] H_LAST = CW'(OPEN_HITS);

    typedef struct packed {
        logic [TW-1:0] tmr;   // 0 = idle, else cycles since off edge
        logic [CW-1:0] hits;  // consecutive positive samples
    } det_t;

    det_t st_d, st_q;
    smp_e smp;

    always_comb begin
        st_d = st_q;
        smp  = SMP_NONE;
        if (clr) begin
            st_d = '0;
        end else begin
            if (off_edge) begin
                st_d.tmr = TW'(1);
            end else if (st_q.tmr != '0) begin
                if (pwm_on) begin
                    // off period ended early: drop it without a sample
                    st_d.tmr = '0;
                end else if (st_q.tmr == T_LAST) begin
                    st_d.tmr = '0;
                    smp      = sense_pos ? SMP_POS : SMP_NEG;
                end else begin
                    st_d.tmr = st_q.tmr + TW'(1);
                end
            end
            case (smp)
                SMP_POS: if (st_q.hits != H_LAST) st_d.hits = st_q.hits + CW'(1);
                SMP_NEG: st_d.hits = '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = (st_q.hits == H_LAST);

endmodule

// File: rtl/drv_fault_hold.sv
module drv_fault_hold
    import drv_fault_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  cause_t cause,
    output logic   fault_o
);

    typedef struct packed {
        logic fault;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)            st_d.fault = 1'b0;
        else if (|cause)    st_d.fault = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_o = st_q.fault;

endmodule

// File: rtl/drv_fault_latch.sv
module drv_fault_latch
    import drv_fault_pkg::*;
#(
    parameter int NPH        = 2,
    parameter int SAMPLE_DLY = 100,
    parameter int OPEN_HITS  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           deep_sleep,
    input  logic [NPH-1:0] oc_trip,
    input  logic           hot_trip,
    input  logic [NPH-1:0] off_edge,
    input  logic [NPH-1:0] pwm_on,
    input  logic [NPH-1:0] sense_pos,
    output logic           fault_flag,
    output logic [NPH-1:0] drive_en
);

    logic [NPH-1:0] open_vec;
    cause_t         cause;
    logic           latched;
    logic           cut_now;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        drv_open_det #(
            .SAMPLE_DLY (SAMPLE_DLY),
            .OPEN_HITS  (OPEN_HITS)
        ) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (deep_sleep),
            .off_edge  (off_edge[p]),
            .pwm_on    (pwm_on[p]),
            .sense_pos (sense_pos[p]),
            .open_o    (open_vec[p])
        );
    end

    always_comb begin
        cause         = '0;
        cause.shorted = |oc_trip;
        cause.hot     = hot_trip;
        cause.open    = |open_vec;
    end

    drv_fault_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (deep_sleep),
        .cause   (cause),
        .fault_o (latched)
    );

    // Short and overheat cut the outputs before the latch registers them
    assign cut_now    = latched | cause.shorted | cause.hot | deep_sleep;
    assign drive_en   = {NPH{~cut_now}};
    assign fault_flag = latched;

endmodule

// File: rtl/drv_fault_latch_chk.sv
module drv_fault_latch_chk #(
    parameter int NPH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           deep_sleep,
    input logic [NPH-1:0] oc_trip,
    input logic           hot_trip,
    input logic [NPH-1:0] drive_en,
    input logic           fault_flag
);

    assert_short_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_trip) |-> (drive_en == '0));

    assert_short_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|oc_trip) && !deep_sleep) |=> fault_flag);

    assert_hot_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hot_trip |-> (drive_en == '0));

    assert_hot_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_trip && !deep_sleep) |=> fault_flag);

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !deep_sleep) |=> fault_flag);

    assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |-> (drive_en == '0));

    assert_sleep_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep |=> !fault_flag);

    assert_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (drive_en == '0));

endmodule

bind drv_fault_latch drv_fault_latch_chk #(.NPH(NPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .deep_sleep (deep_sleep),
    .oc_trip    (oc_trip),
    .hot_trip   (hot_trip),
    .drive_en   (drive_en),
    .fault_flag (fault_flag)
);

// File: tb/drv_fault_latch_bench.sv
module drv_fault_latch_bench;

    localparam int NPH = 2;
    localparam int DLY = 100;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           deep_sleep = 1'b0;
    logic [NPH-1:0] oc_trip = '0;
    logic           hot_trip = 1'b0;
    logic [NPH-1:0] off_edge = '0;
    logic [NPH-1:0] pwm_on = '1;
    logic [NPH-1:0] sense_pos = '1;
    logic           fault_flag;
    logic [NPH-1:0] drive_en;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    drv_fault_latch #(.NPH(NPH), .SAMPLE_DLY(DLY), .OPEN_HITS(3)) u_drv_fault_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .deep_sleep (deep_sleep),
        .oc_trip    (oc_trip),
        .hot_trip   (hot_trip),
        .off_edge   (off_edge),
        .pwm_on     (pwm_on),
        .sense_pos  (sense_pos),
        .fault_flag (fault_flag),
        .drive_en   (drive_en)
    );

    // Off-period codes: 0 negative sample, 1 positive sample, 2 cut short
    typedef struct packed {
        logic           exp;
        logic           ph;
        logic [2:0]     n;
        logic [5:0][1:0] code;   // code[0] is the first period
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 3'd3, {2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1}},  // R4 three in a row
        '{1'b0, 1'b0, 3'd2, {2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1}},  // R4 two only
        '{1'b0, 1'b0, 3'd5, {2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1}},  // R5 break
        '{1'b1, 1'b0, 3'd6, {2'd1, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1}},  // R5 then three
        '{1'b1, 1'b0, 3'd4, {2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 2'd1}},  // R6 short keeps count
        '{1'b0, 1'b0, 3'd4, {2'd0, 2'd0, 2'd2, 2'd2, 2'd2, 2'd2}},  // R6 shorts never count
        '{1'b1, 1'b1, 3'd3, {2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1}},  // R4 phase B
        '{1'b0, 1'b0, 3'd4, {2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0}}   // R5 healthy coil
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic off_period(input int ph, input logic [1:0] code);
        @(negedge clk);
        off_edge[ph]  = 1'b1;
        pwm_on[ph]    = 1'b0;
        sense_pos[ph] = (code != 2'd0);
        @(negedge clk);
        off_edge[ph]  = 1'b0;
        if (code == 2'd2) repeat (DLY / 2) @(negedge clk);
        else              repeat (DLY + 2) @(negedge clk);
        pwm_on[ph]    = 1'b1;
        sense_pos[ph] = 1'b1;   // on-time polarity is ignored (R8)
        repeat (4) @(negedge clk);
    endtask

    task automatic sleep_clear(input string req);
        @(negedge clk);
        deep_sleep = 1'b1;
        @(negedge clk);
        check(drive_en == '0, req, drive_en, 0);
        deep_sleep = 1'b0;
        @(negedge clk);
        check(fault_flag == 1'b0, req, fault_flag, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(fault_flag == 1'b0, "R1 flag", fault_flag, 0);
        check(drive_en == '1, "R1 enables", drive_en, 3);

        // Table walk: open-coil sequences (R4 R5 R6 R8)
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < int'(VECS[v].n); k++)
                off_period(int'(VECS[v].ph), VECS[v].code[k]);
            check(fault_flag == VECS[v].exp, $sformatf("R4/R5/R6 vec%0d flag", v),
                  fault_flag, VECS[v].exp);
            if (VECS[v].exp)
                check(drive_en == '0, $sformatf("R7 vec%0d both off", v), drive_en, 0);
            sleep_clear($sformatf("R10 vec%0d clear", v));
        end

        // R7 separate counters: two on A, two on B
        off_period(0, 2'd1); off_period(0, 2'd1);
        off_period(1, 2'd1); off_period(1, 2'd1);
        check(fault_flag == 1'b0, "R7 split phases", fault_flag, 0);
        check(drive_en == '1, "R7 split enables", drive_en, 3);
        sleep_clear("R10 after split");

        // R10 sleep clears counters
        off_period(0, 2'd1); off_period(0, 2'd1);
        sleep_clear("R10 mid count");
        off_period(0, 2'd1);
        check(fault_flag == 1'b0, "R10 counter cleared", fault_flag, 0);
        sleep_clear("R10 cleanup");

        // R11 constant drive with positive sense
        pwm_on = '1; sense_pos = '1;
        repeat (400) @(negedge clk);
        check(fault_flag == 1'b0, "R11 constant drive", fault_flag, 0);
        check(drive_en == '1, "R11 enables", drive_en, 3);

        // R2 short: immediate cut, then latch that outlives the input (R9)
        @(negedge clk);
        oc_trip[1] = 1'b1;
        #1;
        check(drive_en == '0, "R2 immediate cut", drive_en, 0);
        check(fault_flag == 1'b0, "R2 not yet latched", fault_flag, 0);
        @(negedge clk);
        oc_trip = '0;
        check(fault_flag == 1'b1, "R2 latched", fault_flag, 1);
        repeat (20) @(negedge clk);
        check(fault_flag == 1'b1, "R9 held", fault_flag, 1);
        check(drive_en == '0, "R9 outputs off", drive_en, 0);
        sleep_clear("R9 sleep clears");
        check(drive_en == '1, "R9 enables back", drive_en, 3);

        // R3 overtemperature
        @(negedge clk);
        hot_trip = 1'b1;
        #1;
        check(drive_en == '0, "R3 immediate cut", drive_en, 0);
        @(negedge clk);
        hot_trip = 1'b0;
        check(fault_flag == 1'b1, "R3 latched", fault_flag, 1);

        // R1 reset clears a latched fault
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(fault_flag == 1'b0, "R1 reset clears", fault_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_en == '1, "R1 enables after reset", drive_en, 3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule